// File: doc/BRIEF.md
# Transceiver PLL and Datapath Reset Sequencer

This block brings a serial transceiver channel out of reset once the device has finished start-up. It drives the reset of two PLLs and the resets of the transmit and receive datapaths, and it releases them in order. First the PLL that clocks a direction is reset, held and waited on. Only then is that direction's datapath reset (analog front end and digital coding layer) released. Each direction raises its own done flag once its datapath reports ready.

A single start pulse launches the whole sequence and captures two select inputs, one per direction, that say which PLL clocks transmit and which clocks receive. The two directions have separate sequencers that run side by side. Each one waits only on the PLL it selected, so a slow or failing PLL on one side never holds back the other side. When both directions pick the same PLL, that PLL goes through one reset sequence and both directions watch the same lock signal. A per-direction restart input reruns only that direction's datapath step and leaves the PLLs alone.

Top module: `xcvr_rst_seq`

## Requirements
- R1: After reset, every PLL reset output and both datapath resets are high and both done flags are low. They stay that way until `start` is pulsed.
- R2: On `start`, each select input is captured (value k selects PLL k). A PLL that neither direction selects keeps its reset high. A PLL selected by both directions runs a single reset sequence.
- R3: After `start`, the reset of each selected PLL stays high for exactly PLL_HOLD cycles and is then released.
- R4: If lock is not seen within LOCK_TMO cycles of the PLL reset being released, the PLL reset is raised again for PLL_HOLD cycles and the wait is retried.
- R5: A datapath reset is released only in a cycle where its selected PLL is locked. The release comes no sooner than DP_HOLD cycles after that lock is seen.
- R6: A done flag rises only after its synchronized datapath-ready input has been high for RDY_RUN consecutive cycles. A shorter burst of ready does not raise done.
- R7: The directions are independent. A done flag is high only while its datapath reset is low, and one direction can complete while the other is still waiting on its own PLL.
- R8: If the selected PLL drops lock, that direction clears done and raises its datapath reset within a few cycles, then waits for lock again. The PLL reset is not touched.
- R9: A pulse on `tx_restart` or `rx_restart` reruns only that direction's datapath step. The PLL resets and the other direction's outputs are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches the full sequence |
| tx_sel | input | SEL_W | PLL that clocks transmit, captured on start |
| rx_sel | input | SEL_W | PLL that clocks receive, captured on start |
| tx_restart | input | 1 | Rerun the transmit datapath reset |
| rx_restart | input | 1 | Rerun the receive datapath reset |
| pll_lock | input | N_PLL | Lock indication from each PLL, asynchronous |
| tx_ready | input | 1 | Transmit datapath ready, asynchronous |
| rx_ready | input | 1 | Receive datapath ready, asynchronous |
| pll_rst | output | N_PLL | Reset to each PLL, active high |
| tx_dp_rst | output | 1 | Transmit datapath reset, active high |
| rx_dp_rst | output | 1 | Receive datapath reset, active high |
| tx_done | output | 1 | Transmit initialization complete |
| rx_done | output | 1 | Receive initialization complete |

## Verification
The main sequence is first run with both directions on one PLL. This separates a shared single reset from two separate ones, and shows that the unused PLL stays in reset. It is then run with the directions split across the two PLLs while one PLL never locks. This exposes the timeout-and-retry period and shows whether one direction can finish while the other waits. Lock loss, a single-direction restart and a broken ready burst are then applied in turn. They show whether each recovery path touches only its own direction and leaves the PLL resets alone, and whether the ready run length is counted.

// File: rtl/xcvr_rst_pkg.sv
// Package: shared state encodings for the transceiver reset sequencer.
// Assumes: nothing beyond being compiled before the modules that use it.
package xcvr_rst_pkg;

    // PLL controller states: idle in reset, minimum hold, lock wait, locked
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_HOLD = 2'd1,
        PS_WAIT = 2'd2,
        PS_UP   = 2'd3
    } pll_state_e;

    // Datapath sequencer states
    typedef enum logic [2:0] {
        DS_IDLE = 3'd0,
        DS_WAIT = 3'd1,
        DS_HOLD = 3'd2,
        DS_RDY  = 3'd3,
        DS_DONE = 3'd4
    } dp_state_e;

endpackage

// File: rtl/xcvr_sync2.sv
// Module: two-flop synchronizer for a vector of independent level signals.
// Assumes: each bit is a slow level (lock, ready); no bus coherence is needed.
module xcvr_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta;

    // Two register stages; both clear to zero in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= '0;
            d_sync <= '0;
        end else begin
            meta   <= d_async;
            d_sync <= meta;
        end
    end
endmodule

// File: rtl/xcvr_pll_ctl.sv
// Module: reset controller for one PLL. On go it holds the reset for HOLD
// cycles, then waits up to TMO cycles for lock and retries on timeout.
// Assumes: lock_s is already synchronized; go and drop are never both high.
module xcvr_pll_ctl
    import xcvr_rst_pkg::*;
#(
    parameter int HOLD = 8,
    parameter int TMO  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic drop,
    input  logic lock_s,
    output logic pll_rst,
    output logic pll_up
);
    localparam int MAXC = (HOLD > TMO) ? HOLD : TMO;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int HW   = $clog2(HOLD + 1);

    pll_state_e    st;
    logic [CW-1:0] cnt;

    // Sequence state, registered reset output and registered locked flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= PS_IDLE;
            cnt     <= '0;
            pll_rst <= 1'b1;
            pll_up  <= 1'b0;
        end else if (drop) begin
            st      <= PS_IDLE;
            cnt     <= '0;
            pll_rst <= 1'b1;
            pll_up  <= 1'b0;
        end else if (go) begin
            st      <= PS_HOLD;
            cnt     <= '0;
            pll_rst <= 1'b1;
            pll_up  <= 1'b0;
        end else begin
            case (st)
                PS_HOLD: begin
                    if (cnt == CW'(HOLD - 1)) begin
                        st      <= PS_WAIT;
                        cnt     <= '0;
                        pll_rst <= 1'b0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PS_WAIT: begin
                    if (lock_s) begin
                        st     <= PS_UP;
                        cnt    <= '0;
                        pll_up <= 1'b1;
                    end else if (cnt == CW'(TMO - 1)) begin
                        st      <= PS_HOLD;
                        cnt     <= '0;
                        pll_rst <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    // Checker counter: length of the current run of reset-high cycles
    logic [HW-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run <= '0;
        else if (!pll_rst)
            hi_run <= '0;
        else if (hi_run != HW'(HOLD))
            hi_run <= hi_run + HW'(1);
    end

    // R3
    pll_hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst) |-> (hi_run == HW'(HOLD)));

    // R2
    pll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (pll_rst && !pll_up));

    // R4
    pll_up_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_up |-> !pll_rst);
endmodule

// File: rtl/xcvr_dp_seq.sv
// Module: datapath reset sequencer for one direction. It waits for its PLL to
// lock, holds the datapath reset HOLD more cycles, releases it, and raises
// done after RDY_RUN consecutive ready cycles.
// Assumes: lock_ok and ready_s are synchronous to clk.
module xcvr_dp_seq
    import xcvr_rst_pkg::*;
#(
    parameter int HOLD    = 16,
    parameter int RDY_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic restart,
    input  logic lock_ok,
    input  logic ready_s,
    output logic dp_rst,
    output logic done
);
    localparam int MAXC = (HOLD > RDY_RUN) ? HOLD : RDY_RUN;
    localparam int CW   = $clog2(MAXC + 1);

    dp_state_e     st;
    logic [CW-1:0] cnt;

    // Sequence state with registered datapath reset and done outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= DS_IDLE;
            cnt    <= '0;
            dp_rst <= 1'b1;
            done   <= 1'b0;
        end else if (start || (restart && st != DS_IDLE)) begin
            st     <= DS_WAIT;
            cnt    <= '0;
            dp_rst <= 1'b1;
            done   <= 1'b0;
        end else begin
            case (st)
                DS_WAIT: begin
                    if (lock_ok) begin
                        st  <= DS_HOLD;
                        cnt <= '0;
                    end
                end
                DS_HOLD: begin
                    if (!lock_ok) begin
                        st  <= DS_WAIT;
                        cnt <= '0;
                    end else if (cnt == CW'(HOLD - 1)) begin
                        st     <= DS_RDY;
                        cnt    <= '0;
                        dp_rst <= 1'b0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                DS_RDY: begin
                    if (!lock_ok) begin
                        st     <= DS_WAIT;
                        cnt    <= '0;
                        dp_rst <= 1'b1;
                    end else if (!ready_s) begin
                        cnt <= '0;
                    end else if (cnt == CW'(RDY_RUN - 1)) begin
                        st   <= DS_DONE;
                        cnt  <= '0;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                DS_DONE: begin
                    if (!lock_ok) begin
                        st     <= DS_WAIT;
                        dp_rst <= 1'b1;
                        done   <= 1'b0;
                    end
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    // R5
    dp_release_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dp_rst) |-> $past(lock_ok));

    // R6
    done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ready_s));

    // R7
    done_out_of_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dp_rst);

    // R8
    lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !lock_ok) |=> (!done && dp_rst));
endmodule

// File: rtl/xcvr_rst_seq.sv
// Module: top of the transceiver reset sequencer. One controller per PLL and
// one datapath sequencer per direction. Selects are captured on start.
// Assumes: start comes after device start-up; N_PLL is a power of two so every
// select value names a PLL; lock and ready inputs may be asynchronous.
module xcvr_rst_seq
    import xcvr_rst_pkg::*;
#(
    parameter int N_PLL    = 2,
    parameter int PLL_HOLD = 8,
    parameter int LOCK_TMO = 1024,
    parameter int DP_HOLD  = 16,
    parameter int RDY_RUN  = 4,
    localparam int SEL_W   = (N_PLL > 1) ? $clog2(N_PLL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] tx_sel,
    input  logic [SEL_W-1:0] rx_sel,
    input  logic             tx_restart,
    input  logic             rx_restart,
    input  logic [N_PLL-1:0] pll_lock,
    input  logic             tx_ready,
    input  logic             rx_ready,
    output logic [N_PLL-1:0] pll_rst,
    output logic             tx_dp_rst,
    output logic             rx_dp_rst,
    output logic             tx_done,
    output logic             rx_done
);
    localparam int N_DIR = 2;

    logic [N_PLL-1:0] lock_s;
    logic [N_PLL-1:0] pll_up;
    logic [N_DIR-1:0] ready_s;
    logic [SEL_W-1:0] sel_q [N_DIR];
    logic [N_DIR-1:0] restart_v;
    logic [N_DIR-1:0] lock_ok;
    logic [N_DIR-1:0] dp_rst_v;
    logic [N_DIR-1:0] done_v;

    xcvr_sync2 #(.W(N_PLL)) u_lock_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pll_lock), .d_sync(lock_s)
    );

    xcvr_sync2 #(.W(N_DIR)) u_rdy_sync (
        .clk(clk), .rst_n(rst_n), .d_async({rx_ready, tx_ready}), .d_sync(ready_s)
    );

    // Capture the per-direction PLL selection at each start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q[0] <= '0;
            sel_q[1] <= '0;
        end else if (start) begin
            sel_q[0] <= tx_sel;
            sel_q[1] <= rx_sel;
        end
    end

    genvar gp;
    generate
        for (gp = 0; gp < N_PLL; gp++) begin : g_pll
            logic used;
            // A PLL runs when either direction selects it, else it stays in reset
            assign used = (tx_sel == SEL_W'(gp)) || (rx_sel == SEL_W'(gp));

            xcvr_pll_ctl #(.HOLD(PLL_HOLD), .TMO(LOCK_TMO)) u_pll (
                .clk    (clk),
                .rst_n  (rst_n),
                .go     (start && used),
                .drop   (start && !used),
                .lock_s (lock_s[gp]),
                .pll_rst(pll_rst[gp]),
                .pll_up (pll_up[gp])
            );
        end
    endgenerate

    assign restart_v = {rx_restart, tx_restart};

    genvar gd;
    generate
        for (gd = 0; gd < N_DIR; gd++) begin : g_dir
            // Lock seen by this direction: its PLL finished its sequence and is locked
            assign lock_ok[gd] = pll_up[sel_q[gd]] && lock_s[sel_q[gd]];

            xcvr_dp_seq #(.HOLD(DP_HOLD), .RDY_RUN(RDY_RUN)) u_dp (
                .clk    (clk),
                .rst_n  (rst_n),
                .start  (start),
                .restart(restart_v[gd]),
                .lock_ok(lock_ok[gd]),
                .ready_s(ready_s[gd]),
                .dp_rst (dp_rst_v[gd]),
                .done   (done_v[gd])
            );
        end
    endgenerate

    assign tx_dp_rst = dp_rst_v[0];
    assign rx_dp_rst = dp_rst_v[1];
    assign tx_done   = done_v[0];
    assign rx_done   = done_v[1];

    // R1
    idle_until_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !start) |=> (&dp_rst_v && !(|done_v)));
endmodule

// File: tb/xcvr_rst_seq_test.sv
// Bench: PLL and datapath models plus a done-event scoreboard.
module xcvr_rst_seq_test;
    localparam int N_PLL    = 2;
    localparam int PLL_HOLD = 8;
    localparam int LOCK_TMO = 1024;
    localparam int DP_HOLD  = 16;
    localparam int RDY_RUN  = 4;
    localparam int RDLY     = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             tx_sel = 1'b0, rx_sel = 1'b0;
    logic             tx_restart = 1'b0, rx_restart = 1'b0;
    logic [N_PLL-1:0] pll_lock = '0;
    logic [1:0]       rdy_v = '0;
    logic [N_PLL-1:0] pll_rst;
    logic             tx_dp_rst, rx_dp_rst, tx_done, rx_done;

    xcvr_rst_seq #(
        .N_PLL(N_PLL), .PLL_HOLD(PLL_HOLD), .LOCK_TMO(LOCK_TMO),
        .DP_HOLD(DP_HOLD), .RDY_RUN(RDY_RUN)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tx_sel(tx_sel), .rx_sel(rx_sel),
        .tx_restart(tx_restart), .rx_restart(rx_restart),
        .pll_lock(pll_lock), .tx_ready(rdy_v[0]), .rx_ready(rdy_v[1]),
        .pll_rst(pll_rst), .tx_dp_rst(tx_dp_rst), .rx_dp_rst(rx_dp_rst),
        .tx_done(tx_done), .rx_done(rx_done)
    );

    logic [1:0] dp_rst_v, done_v;
    assign dp_rst_v = {rx_dp_rst, tx_dp_rst};
    assign done_v   = {rx_done, tx_done};

    int  n_chk = 0, n_bad = 0;
    bit  finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // PLL model: lock comes lk_dly cycles after reset release, unless killed
    int         lk_dly [N_PLL] = '{20, 30};
    int         lk_cnt [N_PLL] = '{0, 0};
    logic [1:0] kill = '0;
    always @(negedge clk) begin
        for (int i = 0; i < N_PLL; i++) begin
            if (pll_rst[i]) begin
                lk_cnt[i] = 0;
                pll_lock[i] <= 1'b0;
            end else begin
                if (lk_cnt[i] < lk_dly[i]) lk_cnt[i]++;
                pll_lock[i] <= (lk_cnt[i] >= lk_dly[i]) && !kill[i];
            end
        end
    end

    // Datapath model: ready RDLY cycles after reset release, or driven by hand
    int         rd_cnt [2] = '{0, 0};
    logic [1:0] manual = '0, man_val = '0;
    always @(negedge clk) begin
        for (int d = 0; d < 2; d++) begin
            if (dp_rst_v[d]) rd_cnt[d] = 0;
            else if (rd_cnt[d] < RDLY) rd_cnt[d]++;
            rdy_v[d] <= manual[d] ? man_val[d] : (!dp_rst_v[d] && rd_cnt[d] >= RDLY);
        end
    end

    // Scoreboard of expected done edges: dir 0 = TX, 1 = RX
    typedef struct { int dir; logic val; } ev_t;
    ev_t        exp_q[$];
    logic [1:0] done_prev = '0;
    bit         mon_en = 0;

    task automatic expect_ev(input int dir, input logic val);
        ev_t e;
        e.dir = dir; e.val = val;
        exp_q.push_back(e);
    endtask

    // Monitor: pop and compare each observed done edge, TX before RX
    always @(negedge clk) begin
        if (mon_en) begin
            for (int d = 0; d < 2; d++) begin
                if (done_v[d] !== done_prev[d]) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R7 unexpected done edge", d, -1);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        check(e.dir == d && e.val === done_v[d], "R7 done edge",
                              d * 10 + int'(done_v[d]), e.dir * 10 + int'(e.val));
                    end
                end
            end
        end
        done_prev = done_v;
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input logic [1:0] mask, input int lim, input string req);
        int n = 0;
        while (((done_v & mask) != mask) && n < lim) begin
            @(negedge clk);
            n++;
        end
        check((done_v & mask) == mask, req, done_v, mask);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt, gap;
        bit seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1;
        // R1 reset state
        check(pll_rst == 2'b11, "R1 pll_rst after reset", pll_rst, 3);
        check(dp_rst_v == 2'b11 && done_v == 2'b00, "R1 dp_rst/done after reset",
              {dp_rst_v, done_v}, 12);
        repeat (20) @(negedge clk);
        check(pll_rst == 2'b11 && dp_rst_v == 2'b11 && done_v == 2'b00,
              "R1 idle without start", {pll_rst, dp_rst_v, done_v}, 60);

        // Shared PLL0 for both directions
        tx_sel = 1'b0; rx_sel = 1'b0;
        expect_ev(0, 1'b1); expect_ev(1, 1'b1);
        pulse_start();
        cnt = 0;
        while (pll_rst[0] && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == PLL_HOLD, "R3 PLL0 reset hold", cnt, PLL_HOLD);
        check(pll_rst[1] == 1'b1, "R2 unused PLL1 held", pll_rst[1], 1);
        gap = 0; seen = 0;
        while (tx_dp_rst && gap < 200) begin
            if (seen) gap++;
            if (pll_lock[0]) seen = 1;
            @(negedge clk);
        end
        check(gap >= DP_HOLD && gap <= DP_HOLD + 6, "R5 datapath hold after lock", gap, DP_HOLD);
        check(pll_lock[0] == 1'b1, "R5 released while locked", pll_lock[0], 1);
        wait_done(2'b11, 500, "R6 both done on shared PLL");
        check(pll_rst == 2'b10, "R2 single shared PLL reset", pll_rst, 2);

        // Split PLLs, PLL1 never locks
        kill[1] = 1'b1;
        tx_sel = 1'b0; rx_sel = 1'b1;
        expect_ev(0, 1'b0); expect_ev(1, 1'b0); expect_ev(0, 1'b1);
        pulse_start();
        cnt = 0;
        while (pll_rst[1] && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == PLL_HOLD, "R3 PLL1 reset hold", cnt, PLL_HOLD);
        cnt = 0;
        while (!pll_rst[1] && cnt < 5000) begin cnt++; @(negedge clk); end
        check(cnt == LOCK_TMO, "R4 lock timeout window", cnt, LOCK_TMO);
        cnt = 0;
        while (pll_rst[1] && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == PLL_HOLD, "R4 retry reset hold", cnt, PLL_HOLD);
        check(tx_done == 1'b1 && rx_done == 1'b0, "R7 TX done while RX waits",
              done_v, 1);
        expect_ev(1, 1'b1);
        kill[1] = 1'b0;
        wait_done(2'b10, 3000, "R4 RX done after retry");

        // Lock loss on PLL0
        expect_ev(0, 1'b0);
        kill[0] = 1'b1;
        repeat (6) @(negedge clk);
        check(tx_dp_rst == 1'b1 && tx_done == 1'b0, "R8 TX back in reset on lock loss",
              {tx_dp_rst, tx_done}, 2);
        check(rx_done == 1'b1 && pll_rst == 2'b00, "R8 RX and PLLs untouched",
              {rx_done, pll_rst}, 4);
        expect_ev(0, 1'b1);
        kill[0] = 1'b0;
        wait_done(2'b01, 500, "R8 TX recovers");
        check(pll_rst == 2'b00, "R8 no PLL reset after recovery", pll_rst, 0);

        // RX restart only
        expect_ev(1, 1'b0); expect_ev(1, 1'b1);
        rx_restart = 1'b1;
        @(negedge clk);
        rx_restart = 1'b0;
        repeat (2) @(negedge clk);
        check(rx_dp_rst == 1'b1, "R9 RX datapath reset on restart", rx_dp_rst, 1);
        check(tx_done == 1'b1 && tx_dp_rst == 1'b0, "R9 TX unaffected",
              {tx_done, tx_dp_rst}, 2);
        check(pll_rst == 2'b00, "R9 PLLs not reset by restart", pll_rst, 0);
        wait_done(2'b10, 500, "R9 RX done after restart");
        check(pll_rst == 2'b00, "R9 PLLs still released", pll_rst, 0);

        // Broken ready burst on TX
        manual[0] = 1'b1; man_val[0] = 1'b0;
        expect_ev(0, 1'b0);
        tx_restart = 1'b1;
        @(negedge clk);
        tx_restart = 1'b0;
        cnt = 0;
        while (!tx_dp_rst && cnt < 10) begin cnt++; @(negedge clk); end
        cnt = 0;
        while (tx_dp_rst && cnt < 200) begin cnt++; @(negedge clk); end
        check(tx_dp_rst == 1'b0, "R6 TX released for ready test", tx_dp_rst, 0);
        man_val[0] = 1'b1;
        repeat (RDY_RUN - 1) @(negedge clk);
        man_val[0] = 1'b0;
        repeat (RDY_RUN + 2) @(negedge clk);
        check(tx_done == 1'b0, "R6 short ready burst ignored", tx_done, 0);
        expect_ev(0, 1'b1);
        man_val[0] = 1'b1;
        wait_done(2'b01, 20, "R6 done after full ready run");
        manual[0] = 1'b0;

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R7 all done edges seen", exp_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule